// File: doc/BRIEF.md
# Cascadable Ternary Lookup Engine

This block is a small ternary content-addressable lookup engine. Each entry holds a data word, a per-bit care mask and a valid flag. Operations enter on a shared request port: a strobe, a four-bit command and one bus that carries an entry address and a data word, or a search key. The commands write data words, write care masks, drop entries, load global mask registers, set the engine enable bit, read entries back, and run lookups. A lookup compares the key against every valid entry in parallel. Each bit is filtered by both the entry's care mask and a global mask register that the command selects. The engine returns the binary index of the lowest-numbered hit, a hit flag and a completion flag.

Several engines can be chained by priority. Each engine drives a combinational match output that reports its own local hit one cycle after the strobe. Any engine that sees its match input asserted at that point reports a miss, so a hit in a higher-priority engine always overrides a local hit. Results and read data appear two clock cycles after the strobe.

Top module: `tsrch_engine`

## Requirements
- R1: An operation starts only at a rising edge where `req_strobe_i` is 1, and `req_cmd_i` is sampled at that edge. Command codes: `0001` writes the data word and marks the entry valid. `0010` writes the care mask. `0011` loads global mask register number `addr[GSEL_W-1:0]`. `0100` writes the enable bit from `key[0]`. `0101` drops the entry. `0110` reads the data word. `0111` reads the care mask. `1ggg` runs a lookup with global mask register `ggg`.
- R2: On the request bus, bits `[KEY_W-1:0]` are the data word or key and bits `[KEY_W+IDX_W-1:KEY_W]` are the entry address. A lookup applies only the global mask register that the command selects. Global mask registers reset to all ones.
- R3: A key bit matches an entry bit when the entry's care bit is 0, or the selected global mask bit is 0, or the two bits are equal. An entry hits when every bit matches and the entry is valid. Care masks reset to all ones.
- R4: When several entries hit, `idx_o` holds the binary index of the lowest-numbered one.
- R5: `hit_o` is 1 on a reported hit and 0 on a miss. It is updated together with `idx_o`, and `idx_o` is 0 on a miss.
- R6: For every lookup started while the engine is enabled, `lk_valid_o` is a one-cycle pulse two cycles after the strobe, whether the lookup hit or missed.
- R7: If `match_in_i` is 1 one cycle after a lookup strobe, that lookup reports `hit_o`=0 and `idx_o`=0, while `lk_valid_o` still pulses.
- R8: `match_out_o` is 1 in the cycle after a lookup strobe exactly when this engine has a local hit. It ignores `match_in_i`.
- R9: Reset clears the enable bit. A lookup issued while the engine is disabled produces no `lk_valid_o` pulse and no `match_out_o`.
- R10: A read returns the data word or care mask on `rd_data_o` with a one-cycle `rd_ack_o` pulse two cycles after the strobe.
- R11: A dropped entry no longer hits. A later data write makes the entry valid again.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_strobe_i | input | 1 | Request valid; starts one operation |
| req_cmd_i | input | 4 | Operation code and global mask select |
| req_bus_i | input | KEY_W+IDX_W | Entry address in the upper bits, data or key in the lower bits |
| match_in_i | input | 1 | Hit reported by a higher-priority engine |
| idx_o | output | IDX_W | Index of the winning entry |
| hit_o | output | 1 | Reported hit (1) or miss (0) |
| lk_valid_o | output | 1 | Lookup-complete pulse |
| rd_ack_o | output | 1 | Read-data-valid pulse |
| rd_data_o | output | KEY_W | Data word or care mask that was read |
| match_out_o | output | 1 | Local hit, to lower-priority engines |

## Verification
A corrupted entry word, care mask or valid flag shows up on the very next lookup that touches that entry: the hit turns into a miss, or `idx_o` names the wrong entry two cycles after the strobe. A readback shows the same error two cycles after a read. A wrong global mask register selection shows up as a hit or miss that depends on the key bits that should have been masked out. A stuck enable bit shows up one cycle after the strobe, as a `match_out_o` that should not be there, and one cycle later as a missing or extra `lk_valid_o` pulse. A broken cascade shows up as a `hit_o` that stays 1 while the match input is asserted.

// File: rtl/tsrch_pkg.sv
// Package: shared command codes and write kinds for the ternary lookup engine.
// Assumes a four-bit command: bit 3 marks a lookup, bits 2:0 give the operation or mask select.
package tsrch_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_WR_DATA = 3'd1,
        OP_WR_CARE = 3'd2,
        OP_WR_GMR  = 3'd3,
        OP_WR_CTRL = 3'd4,
        OP_DROP    = 3'd5,
        OP_RD_DATA = 3'd6,
        OP_RD_CARE = 3'd7
    } op_t;

    typedef enum logic [1:0] {
        WK_DATA = 2'd0,
        WK_CARE = 2'd1,
        WK_DROP = 2'd2,
        WK_NONE = 2'd3
    } wr_kind_t;

endpackage

// File: rtl/tsrch_entry_array.sv
// Entry store: data word, care mask and valid flag per entry, with a parallel ternary compare.
// Assumes writes arrive already decoded. The compare inputs come from the request stage
// registers, so the hit vector is stable for a whole cycle.
module tsrch_entry_array
    import tsrch_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  wr_kind_t           wr_kind,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [KEY_W-1:0]   wr_word,
    input  logic [KEY_W-1:0]   cmp_key,
    input  logic [KEY_W-1:0]   cmp_gmask,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic [IDX_W-1:0]   rd_addr,
    input  logic               rd_care_sel,
    output logic [KEY_W-1:0]   rd_word
);

    logic [KEY_W-1:0]   data_q [ENTRIES];
    logic [KEY_W-1:0]   care_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Purpose: reset the store, then apply one decoded write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                data_q[i] <= '0;
                care_q[i] <= '1;
            end
            valid_q <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                WK_DATA: begin
                    data_q[wr_addr]  <= wr_word;
                    valid_q[wr_addr] <= 1'b1;
                end
                WK_CARE: care_q[wr_addr]  <= wr_word;
                WK_DROP: valid_q[wr_addr] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Purpose: one ternary comparator per entry; a bit counts only where care and global mask are both 1.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] & ~|((cmp_key ^ data_q[g]) & care_q[g] & cmp_gmask);
    end

    // Purpose: readback mux for the data word or the care mask.
    always_comb begin
        rd_word = rd_care_sel ? care_q[rd_addr] : data_q[rd_addr];
    end

    AST_DATA_WRITE_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_DATA) |=> valid_q[$past(wr_addr)]); // R11
    AST_DROP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_DROP) |=> !hit_vec[$past(wr_addr)]); // R11

endmodule

// File: rtl/tsrch_prio_enc.sv
// Priority encoder: reports whether any hit exists and the binary index of the lowest set bit.
// Assumes N fits in IW bits. The logic is purely combinational.
module tsrch_prio_enc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [N-1:0] below_mask;

    // Purpose: scan from the top so that the lowest set bit is assigned last and wins.
    always_comb begin
        found = |hits;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    // Purpose: mask of the positions below the chosen index, used only by the check below.
    always_comb begin
        below_mask = (N'(1) << idx) - N'(1);
    end

    // Purpose: the chosen position must be set and no lower position may be set.
    always_comb begin
        if (found) begin
            AST_LOWEST_WINS: assert (hits[idx] && ((hits & below_mask) == '0)); // R4
        end
    end

endmodule

// File: rtl/tsrch_cmd_decode.sv
// Command decoder and request stage: turns a strobed command into entry writes, global mask
// loads and enable updates, and registers lookup and read requests for the following cycle.
// Assumes GMR_COUNT is at most 8 and that GSEL_W is not wider than IDX_W.
module tsrch_cmd_decode
    import tsrch_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int IDX_W     = 4,
    parameter int GMR_COUNT = 4,
    localparam int BUS_W    = KEY_W + IDX_W,
    localparam int GSEL_W   = (GMR_COUNT > 1) ? $clog2(GMR_COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [CMD_W-1:0] cmd,
    input  logic [BUS_W-1:0] bus,
    output logic             wr_en,
    output wr_kind_t         wr_kind,
    output logic [IDX_W-1:0] wr_addr,
    output logic [KEY_W-1:0] wr_word,
    output logic             st_lookup_q,
    output logic             st_read_q,
    output logic             st_rd_care_q,
    output logic [IDX_W-1:0] st_addr_q,
    output logic [KEY_W-1:0] st_key_q,
    output logic [KEY_W-1:0] st_gmask_q
);

    logic [KEY_W-1:0]  gmr_q [GMR_COUNT];
    logic              en_q;
    op_t               op;
    logic              is_lookup;
    logic              is_plain;
    logic              is_read;
    logic              gmr_wr;
    logic [GSEL_W-1:0] lk_sel;
    logic [GSEL_W-1:0] gmr_wr_sel;
    logic [KEY_W-1:0]  sel_gmask;

    // Purpose: split the command and bus into fields and decode the operation.
    always_comb begin
        op         = op_t'(cmd[2:0]);
        is_lookup  = strobe & cmd[3];
        is_plain   = strobe & ~cmd[3];
        is_read    = is_plain & ((op == OP_RD_DATA) | (op == OP_RD_CARE));
        gmr_wr     = is_plain & (op == OP_WR_GMR);
        wr_addr    = bus[KEY_W +: IDX_W];
        wr_word    = bus[KEY_W-1:0];
        lk_sel     = cmd[GSEL_W-1:0];
        gmr_wr_sel = wr_addr[GSEL_W-1:0];
        wr_en      = 1'b0;
        wr_kind    = WK_NONE;
        if (is_plain) begin
            case (op)
                OP_WR_DATA: begin wr_en = 1'b1; wr_kind = WK_DATA; end
                OP_WR_CARE: begin wr_en = 1'b1; wr_kind = WK_CARE; end
                OP_DROP:    begin wr_en = 1'b1; wr_kind = WK_DROP; end
                default: ;
            endcase
        end
    end

    // Purpose: pick the global mask register named by the lookup command (all ones if out of range).
    always_comb begin
        sel_gmask = '1;
        for (int i = 0; i < GMR_COUNT; i++) begin
            if (lk_sel == GSEL_W'(i)) sel_gmask = gmr_q[i];
        end
    end

    // Purpose: one register per global mask, loaded by its own write command.
    for (genvar g = 0; g < GMR_COUNT; g++) begin : g_gmr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gmr_q[g] <= '1;
            end else if (gmr_wr && gmr_wr_sel == GSEL_W'(g)) begin
                gmr_q[g] <= wr_word;
            end
        end
    end

    // Purpose: the engine enable bit, cleared by reset and written by the control command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (is_plain && op == OP_WR_CTRL) begin
            en_q <= wr_word[0];
        end
    end

    // Purpose: request stage holding lookup and read operands for the compare cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_lookup_q  <= 1'b0;
            st_read_q    <= 1'b0;
            st_rd_care_q <= 1'b0;
            st_addr_q    <= '0;
            st_key_q     <= '0;
            st_gmask_q   <= '1;
        end else begin
            st_lookup_q <= is_lookup & en_q;
            st_read_q   <= is_read;
            if (is_read) begin
                st_addr_q    <= wr_addr;
                st_rd_care_q <= (op == OP_RD_CARE);
            end
            if (is_lookup) begin
                st_key_q   <= wr_word;
                st_gmask_q <= sel_gmask;
            end
        end
    end

    AST_LOOKUP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_lookup_q |-> $past(en_q)); // R9
    AST_STAGE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lookup_q || st_read_q) |-> $past(strobe)); // R1

endmodule

// File: rtl/tsrch_engine.sv
// Top level of the cascadable ternary lookup engine: decoder, entry store, priority
// encoder and result stage. Results are registered two cycles after the strobe. The local
// hit is presented combinationally on the match output in the cycle between.
// Assumes the match input already combines every upstream engine's match output.
module tsrch_engine
    import tsrch_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int KEY_W     = 16,
    parameter int GMR_COUNT = 4,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int BUS_W    = KEY_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_strobe_i,
    input  logic [3:0]       req_cmd_i,
    input  logic [BUS_W-1:0] req_bus_i,
    input  logic             match_in_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             hit_o,
    output logic             lk_valid_o,
    output logic             rd_ack_o,
    output logic [KEY_W-1:0] rd_data_o,
    output logic             match_out_o
);

    logic               wr_en;
    wr_kind_t           wr_kind;
    logic [IDX_W-1:0]   wr_addr;
    logic [KEY_W-1:0]   wr_word;
    logic               st_lookup_q;
    logic               st_read_q;
    logic               st_rd_care_q;
    logic [IDX_W-1:0]   st_addr_q;
    logic [KEY_W-1:0]   st_key_q;
    logic [KEY_W-1:0]   st_gmask_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [KEY_W-1:0]   rd_word;
    logic               found;
    logic [IDX_W-1:0]   enc_idx;
    logic               report_hit;

    tsrch_cmd_decode #(
        .KEY_W     (KEY_W),
        .IDX_W     (IDX_W),
        .GMR_COUNT (GMR_COUNT)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (req_strobe_i),
        .cmd          (req_cmd_i),
        .bus          (req_bus_i),
        .wr_en        (wr_en),
        .wr_kind      (wr_kind),
        .wr_addr      (wr_addr),
        .wr_word      (wr_word),
        .st_lookup_q  (st_lookup_q),
        .st_read_q    (st_read_q),
        .st_rd_care_q (st_rd_care_q),
        .st_addr_q    (st_addr_q),
        .st_key_q     (st_key_q),
        .st_gmask_q   (st_gmask_q)
    );

    tsrch_entry_array #(
        .ENTRIES (ENTRIES),
        .KEY_W   (KEY_W),
        .IDX_W   (IDX_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_kind     (wr_kind),
        .wr_addr     (wr_addr),
        .wr_word     (wr_word),
        .cmp_key     (st_key_q),
        .cmp_gmask   (st_gmask_q),
        .hit_vec     (hit_vec),
        .rd_addr     (st_addr_q),
        .rd_care_sel (st_rd_care_q),
        .rd_word     (rd_word)
    );

    tsrch_prio_enc #(
        .N  (ENTRIES),
        .IW (IDX_W)
    ) u_prio (
        .hits  (hit_vec),
        .found (found),
        .idx   (enc_idx)
    );

    // Purpose: local hit to the chain, and the report qualified by upstream priority.
    always_comb begin
        match_out_o = st_lookup_q & found;
        report_hit  = found & ~match_in_i;
    end

    // Purpose: result and readback stage; flags pulse and data hold until the next operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid_o <= 1'b0;
            hit_o      <= 1'b0;
            idx_o      <= '0;
            rd_ack_o   <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            lk_valid_o <= st_lookup_q;
            rd_ack_o   <= st_read_q;
            if (st_lookup_q) begin
                hit_o <= report_hit;
                idx_o <= report_hit ? enc_idx : '0;
            end
            if (st_read_q) begin
                rd_data_o <= rd_word;
            end
        end
    end

    AST_RESULT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_o |-> $past(req_strobe_i, 2)); // R6
    AST_READ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_o |-> $past(req_strobe_i, 2)); // R10
    AST_UPSTREAM_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_o |-> (hit_o == ($past(match_out_o) && !$past(match_in_i)))); // R7
    AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_o && !hit_o) |-> (idx_o == '0)); // R5
    AST_MATCH_OUT_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        match_out_o |=> lk_valid_o); // R8

endmodule

// File: tb/tb_tsrch_engine.sv
module tb_tsrch_engine;

    localparam int ENTRIES = 16;
    localparam int KEY_W   = 16;
    localparam int IDX_W   = 4;
    localparam int BUS_W   = KEY_W + IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_strobe_i = 1'b0;
    logic [3:0]       req_cmd_i = '0;
    logic [BUS_W-1:0] req_bus_i = '0;
    logic             match_in_i = 1'b0;
    logic [IDX_W-1:0] idx_o;
    logic             hit_o;
    logic             lk_valid_o;
    logic             rd_ack_o;
    logic [KEY_W-1:0] rd_data_o;
    logic             match_out_o;

    int checks = 0;
    int errors = 0;

    tsrch_engine #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .GMR_COUNT(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_strobe_i(req_strobe_i), .req_cmd_i(req_cmd_i),
        .req_bus_i(req_bus_i), .match_in_i(match_in_i), .idx_o(idx_o), .hit_o(hit_o),
        .lk_valid_o(lk_valid_o), .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o),
        .match_out_o(match_out_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobed command; returns at the falling edge just after the sampling edge.
    task automatic issue(input logic [3:0] cmd, input int addr, input logic [KEY_W-1:0] word);
        @(negedge clk);
        req_strobe_i = 1'b1;
        req_cmd_i    = cmd;
        req_bus_i    = {IDX_W'(addr), word};
        @(negedge clk);
        req_strobe_i = 1'b0;
        req_cmd_i    = '0;
        req_bus_i    = '0;
    endtask

    task automatic wr_entry(input int addr, input logic [KEY_W-1:0] data, input logic [KEY_W-1:0] care);
        issue(4'b0001, addr, data);
        issue(4'b0010, addr, care);
    endtask

    task automatic lookup(input string req, input int gsel, input logic [KEY_W-1:0] key,
                          input logic exp_mo, input logic exp_v, input logic exp_hit, input int exp_idx);
        issue(4'b1000 | 4'(gsel), 0, key);
        chk({req, " match_out"}, 32'(match_out_o), 32'(exp_mo));
        chk({req, " lk_valid early"}, 32'(lk_valid_o), 32'd0);
        @(negedge clk);
        chk({req, " lk_valid"}, 32'(lk_valid_o), 32'(exp_v));
        if (exp_v) begin
            chk({req, " hit"}, 32'(hit_o), 32'(exp_hit));
            chk({req, " idx"}, 32'(idx_o), 32'(exp_idx));
        end
        @(negedge clk);
        chk({req, " lk_valid pulse"}, 32'(lk_valid_o), 32'd0);
    endtask

    task automatic read_back(input string req, input logic care, input int addr, input logic [KEY_W-1:0] exp);
        issue(care ? 4'b0111 : 4'b0110, addr, '0);
        chk({req, " rd_ack early"}, 32'(rd_ack_o), 32'd0);
        @(negedge clk);
        chk({req, " rd_ack"}, 32'(rd_ack_o), 32'd1);
        chk({req, " rd_data"}, 32'(rd_data_o), 32'(exp));
        @(negedge clk);
        chk({req, " rd_ack pulse"}, 32'(rd_ack_o), 32'd0);
    endtask

    task automatic t_reset_state();
        chk("R12 idx", 32'(idx_o), 0);
        chk("R12 hit", 32'(hit_o), 0);
        chk("R12 lk_valid", 32'(lk_valid_o), 0);
        chk("R12 rd_ack", 32'(rd_ack_o), 0);
        chk("R12 rd_data", 32'(rd_data_o), 0);
        chk("R12 match_out", 32'(match_out_o), 0);
    endtask

    task automatic t_disabled_after_reset();
        wr_entry(2, 16'h5A5A, 16'hFFFF);
        lookup("R9 disabled after reset", 0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 0);
        issue(4'b0101, 2, '0);
        issue(4'b0100, 0, 16'h0001);
    endtask

    task automatic t_basic_priority();
        wr_entry(3, 16'hA5A5, 16'hFFFF);
        wr_entry(7, 16'hA500, 16'hFF00);
        wr_entry(10, 16'h1234, 16'hFFFF);
        lookup("R4 two hits lowest wins", 0, 16'hA5A5, 1'b1, 1'b1, 1'b1, 3);
        lookup("R3 care bits ignored", 0, 16'hA5FF, 1'b1, 1'b1, 1'b1, 7);
        lookup("R3 exact entry", 0, 16'h1234, 1'b1, 1'b1, 1'b1, 10);
        lookup("R5 R6 miss", 0, 16'h0000, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_global_mask();
        issue(4'b0011, 1, 16'h00FF);
        lookup("R2 gmr1 masks high byte", 1, 16'h9934, 1'b1, 1'b1, 1'b1, 7);
        lookup("R2 gmr1 low byte", 1, 16'h99A5, 1'b1, 1'b1, 1'b1, 3);
        lookup("R2 gmr0 unchanged", 0, 16'h9934, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_cascade();
        match_in_i = 1'b1;
        lookup("R7 R8 upstream hit", 0, 16'hA5A5, 1'b1, 1'b1, 1'b0, 0);
        match_in_i = 1'b0;
        lookup("R7 local hit again", 0, 16'hA5A5, 1'b1, 1'b1, 1'b1, 3);
    endtask

    task automatic t_readback();
        read_back("R10 data word", 1'b0, 7, 16'hA500);
        read_back("R10 care mask", 1'b1, 7, 16'hFF00);
        read_back("R10 default care", 1'b1, 12, 16'hFFFF);
    endtask

    task automatic t_drop();
        issue(4'b0101, 3, '0);
        lookup("R11 dropped entry", 0, 16'hA5A5, 1'b1, 1'b1, 1'b1, 7);
        issue(4'b0001, 3, 16'hA5A5);
        lookup("R11 rewritten entry", 0, 16'hA5A5, 1'b1, 1'b1, 1'b1, 3);
    endtask

    task automatic t_edges();
        wr_entry(0, 16'h0F0F, 16'hFFFF);
        wr_entry(15, 16'hBEEF, 16'hFFFF);
        lookup("R4 last entry", 0, 16'hBEEF, 1'b1, 1'b1, 1'b1, 15);
        lookup("R4 first entry", 0, 16'h0F0F, 1'b1, 1'b1, 1'b1, 0);
        issue(4'b0010, 15, 16'h0000);
        lookup("R3 all dont care", 0, 16'h5555, 1'b1, 1'b1, 1'b1, 15);
        lookup("R4 entry 0 over wildcard", 0, 16'h0F0F, 1'b1, 1'b1, 1'b1, 0);
    endtask

    task automatic t_disable();
        issue(4'b0100, 0, 16'h0000);
        lookup("R9 disabled by control", 0, 16'h0F0F, 1'b0, 1'b0, 1'b0, 0);
        chk("R1 idle idx holds", 32'(idx_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_disabled_after_reset();
        t_basic_priority();
        t_global_mask();
        t_cascade();
        t_readback();
        t_drop();
        t_edges();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule